// File: doc/BRIEF.md
# Clock-Tile Divider Reprogramming Sequencer

This block reprograms the divider, lock and loop-filter settings of an on-chip clock synthesis tile through that tile's 16-bit configuration port. A single start strobe hands it three settings: a feedback multiplier and an output divider, both in eighths (three fraction bits), and an integer input divider. It splits each setting into high and low counts with parity, bypass and fractional-phase flags. It picks a power word, a lock word and a filter word from the multiplier value, then updates thirteen tile registers in a fixed order. Each update reads the register, keeps the bits that lie outside its mask, and writes the merged value back.

A controller upstream works out the settings and pulses `start_i`. A port bridge downstream carries out each single-cycle request and answers with `cfg_rdy_i`. The sequencer raises `busy_o` while it works and pulses `done_o` when the last write has been acknowledged. It pulses `err_o` instead of starting when a setting is unusable.

The control is a six-state machine:
- IDLE waits for a start.
- RD_REQ issues a read.
- RD_WAIT waits for its acknowledge and captures the read data.
- WR_REQ issues the merged write.
- WR_WAIT waits for its acknowledge. It returns to RD_REQ for the next register or goes to FINISH after the last one.
- FINISH pulses done and returns to IDLE.

An invalid start in IDLE raises the error flag and the machine stays in IDLE.

Top module: `clkcfg_seq`

## Requirements
- R1: A start in IDLE with a zero input divider, or with a multiplier or output divider whose integer part (value >> 3) is zero, drives `err_o` high for exactly the one cycle after the start edge. It produces no port request and leaves `busy_o` low.
- R2: A valid start produces 13 read-then-write pairs, each pair to one address. The addresses come in this order: 0x28, 0x08, 0x09, 0x07, 0x16, 0x14, 0x15, 0x13, 0x18, 0x19, 0x1A, 0x4E, 0x4F.
- R3: Every write carries (read data AND NOT mask) OR (value AND mask). The masks in address order are 0x9800, 0xEFFF, 0x7FFF, 0x3C00, 0x3FFF, 0xEFFF, 0x7FFF, 0x3C00, 0x03FF, 0x7FFF, 0x7FFF, 0x9900, 0x9900.
- R4: Each request is a one-cycle `cfg_en_o` pulse with `cfg_we_o` set to 1 for a write and 0 for a read. No request is issued while an earlier one is still unacknowledged. Read data is taken in the cycle `cfg_rdy_i` is high.
- R5: An integer divider part of exactly 1 encodes as bypass = 1 with every other field 0, whatever its fraction.
- R6: An integer divider part n > 1 with fraction 0 encodes as high = n/2, parity = n mod 2, low = n - high, and all fractional fields 0.
- R7: An integer divider part n > 1 with fraction f ≠ 0 encodes as follows:
  - frac_en = 1, frac = f, parity = n mod 2, high = low = n/2.
  - For even n: high is reduced by 1 and wf_r = 1.
  - For even n, or for f = 1: low is reduced by 1.
  - wf_f = 1 when (parity = 0) XOR (f = 1), or when n = 2 and f = 1.
  - phase = parity*4 + f/2.
- R8: The output divider (registers 0x08, 0x09, 0x07) and the multiplier (registers 0x14, 0x15, 0x13) are written in three words:
  - count word: high<<6 | low
  - control word: frac<<12 | frac_en<<11 | wf_r<<10 | parity<<7 | bypass<<6
  - phase word: phase<<11 | wf_f<<10

  The input divider is encoded with fraction 0 and written to 0x16 as parity<<13 | bypass<<12 | high<<6 | low.
- R9: The value written to 0x28 is 0x9800 when the multiplier or the output divider has a nonzero fraction, and 0 otherwise.
- R10: The lock word L is taken from a 36-entry table indexed by i = multiplier - 1. For i ≥ 36 it is 0x1F1F00FA; for example, i = 7 gives 0x161603E8 and i = 18 gives 0x1F1F020D. The lock values are:
  - 0x18: L[9:0]
  - 0x19: L[20:16]<<10 | 0x001
  - 0x1A: L[28:24]<<10 | 0x3E9
- R11: The filter word F is chosen by the same index. Indices 13 to 22 give 0x01001090, 23 to 36 give 0x01008090, 37 to 46 give 0x08001090, and 47 or more give 0x08008090. F[31:16] goes to 0x4E and F[15:0] goes to 0x4F.
- R12: `done_o` is high for exactly one cycle, the cycle after the one in which the final write is acknowledged. `busy_o` is high from the cycle after a valid start up to and including that done cycle.
- R13: A start while `busy_o` is high, including one in the done cycle, is ignored whatever its values. It raises no error and adds no port traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| mult_i | input | MULT_W | Feedback multiplier in eighths |
| divin_i | input | DIVIN_W | Integer input divider |
| divout_i | input | DIVOUT_W | Output divider in eighths |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| cfg_en_o | output | 1 | One-cycle port request |
| cfg_we_o | output | 1 | Request is a write (1) or read (0) |
| cfg_addr_o | output | ADDR_W | Tile register address |
| cfg_wdata_o | output | 16 | Merged write data |
| cfg_rdata_i | input | 16 | Read data, valid with cfg_rdy_i |
| cfg_rdy_i | input | 1 | Request acknowledge |

## Verification
Two functions can meet in one cycle. A new start can arrive in the very cycle that `done_o` fires, and a start with invalid settings can arrive while the machine is partway through a sequence. Either one could be taken as a fresh request or raise the error flag. The bench provokes both inside one sequence: it injects an invalid start a few cycles after launch and a valid start in the cycle it sees the done pulse. It then judges that the error flag never rose, that the port log still holds exactly the 26 expected operations, and that `busy_o` has fallen. The acknowledge latency of the port model varies from one operation to the next, so that each wait state is exercised.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    // Width of the integer count fields produced by the divider encoder.
    localparam int CNT_W     = 8;
    localparam int WORD_W    = 16;
    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef struct packed {
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
        logic             odd;
        logic             nocount;
        logic             frac_en;
        logic [2:0]       frac;
        logic             wf_r;
        logic             wf_f;
        logic [2:0]       phase;
    } div_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/clkcfg_div_enc.sv
module clkcfg_div_enc
    import clkcfg_pkg::*;
(
    input  logic [CNT_W-1:0] int_i,
    input  logic [2:0]       frac_i,
    output div_fields_t      fld_o
);

    logic [CNT_W-1:0] half;
    logic             even;
    logic             f_one;

    assign half  = int_i >> 1;
    assign even  = ~int_i[0];
    assign f_one = (frac_i == 3'd1);

    always_comb begin
        fld_o = '0;
        if (int_i == CNT_W'(1)) begin
            // R5: bypass only
            fld_o.nocount = 1'b1;
        end else if (frac_i == 3'd0) begin
            // R6: integer split
            fld_o.high = half;
            fld_o.odd  = int_i[0];
            fld_o.low  = int_i - half;
        end else begin
            // R7: fractional split
            fld_o.frac_en = 1'b1;
            fld_o.frac    = frac_i;
            fld_o.odd     = int_i[0];
            fld_o.high    = even ? half - CNT_W'(1) : half;
            fld_o.wf_r    = even;
            fld_o.low     = (even || f_one) ? half - CNT_W'(1) : half;
            fld_o.wf_f    = (even ^ f_one) || (int_i == CNT_W'(2) && f_one);
            fld_o.phase   = {int_i[0], frac_i[2:1]};
        end
    end

endmodule

// File: rtl/clkcfg_lut.sv
module clkcfg_lut #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [31:0]      lock_o,
    output logic [31:0]      filter_o
);

    int unsigned idx_n;
    assign idx_n = 32'(idx_i);

    always_comb begin
        case (idx_n)
            0, 1:    lock_o = 32'h0606_03E8;
            2:       lock_o = 32'h0808_03E8;
            3:       lock_o = 32'h0B0B_03E8;
            4:       lock_o = 32'h0E0E_03E8;
            5:       lock_o = 32'h1111_03E8;
            6:       lock_o = 32'h1313_03E8;
            7:       lock_o = 32'h1616_03E8;
            8:       lock_o = 32'h1919_03E8;
            9:       lock_o = 32'h1C1C_03E8;
            10:      lock_o = 32'h1F1F_0384;
            11:      lock_o = 32'h1F1F_0339;
            12:      lock_o = 32'h1F1F_02EE;
            13:      lock_o = 32'h1F1F_02BC;
            14:      lock_o = 32'h1F1F_028A;
            15:      lock_o = 32'h1F1F_0271;
            16:      lock_o = 32'h1F1F_023F;
            17:      lock_o = 32'h1F1F_0226;
            18:      lock_o = 32'h1F1F_020D;
            19:      lock_o = 32'h1F1F_01F4;
            20:      lock_o = 32'h1F1F_01DB;
            21:      lock_o = 32'h1F1F_01C2;
            22:      lock_o = 32'h1F1F_01A9;
            23, 24:  lock_o = 32'h1F1F_0190;
            25:      lock_o = 32'h1F1F_0177;
            26, 27:  lock_o = 32'h1F1F_015E;
            28, 29:  lock_o = 32'h1F1F_0145;
            30, 31, 32: lock_o = 32'h1F1F_012C;
            33, 34, 35: lock_o = 32'h1F1F_0113;
            default: lock_o = 32'h1F1F_00FA;
        endcase
    end

    always_comb begin
        if      (idx_n == 0)  filter_o = 32'h0100_1990;
        else if (idx_n == 1)  filter_o = 32'h0100_1190;
        else if (idx_n == 2)  filter_o = 32'h0100_9890;
        else if (idx_n == 3)  filter_o = 32'h0100_1890;
        else if (idx_n == 4)  filter_o = 32'h0100_8890;
        else if (idx_n <= 8)  filter_o = 32'h0100_9090;
        else if (idx_n <= 11) filter_o = 32'h0100_0890;
        else if (idx_n == 12) filter_o = 32'h0800_9090;
        else if (idx_n <= 22) filter_o = 32'h0100_1090;
        else if (idx_n <= 36) filter_o = 32'h0100_8090;
        else if (idx_n <= 46) filter_o = 32'h0800_1090;
        else                  filter_o = 32'h0800_8090;
    end

endmodule

// File: rtl/clkcfg_step_map.sv
module clkcfg_step_map
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [STEP_W-1:0] step_i,
    input  div_fields_t       out_f,
    input  div_fields_t       in_f,
    input  div_fields_t       fb_f,
    input  logic [31:0]       lock_i,
    input  logic [31:0]       filter_i,
    input  logic [WORD_W-1:0] power_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] val_o
);

    function automatic logic [WORD_W-1:0] cnt_word(div_fields_t f);
        return (WORD_W'(f.high) << 6) | WORD_W'(f.low);
    endfunction

    function automatic logic [WORD_W-1:0] ctl_word(div_fields_t f);
        return (WORD_W'(f.frac) << 12) | (WORD_W'(f.frac_en) << 11) |
               (WORD_W'(f.wf_r) << 10) | (WORD_W'(f.odd) << 7) |
               (WORD_W'(f.nocount) << 6);
    endfunction

    function automatic logic [WORD_W-1:0] ph_word(div_fields_t f);
        return (WORD_W'(f.phase) << 11) | (WORD_W'(f.wf_f) << 10);
    endfunction

    logic [WORD_W-1:0] in_word;
    assign in_word = (WORD_W'(in_f.odd) << 13) | (WORD_W'(in_f.nocount) << 12) | cnt_word(in_f);

    // Fields of the input divider and lock word that no register takes.
    logic unused_bits;
    assign unused_bits = ^{in_f.frac_en, in_f.frac, in_f.wf_r, in_f.wf_f, in_f.phase,
                           lock_i[15:10], lock_i[23:21], lock_i[31:29]};

    always_comb begin
        addr_o = '0;
        mask_o = '0;
        val_o  = '0;
        case (step_i)
            4'd0:  begin addr_o = ADDR_W'(8'h28); mask_o = 16'h9800; val_o = power_i;       end
            4'd1:  begin addr_o = ADDR_W'(8'h08); mask_o = 16'hEFFF; val_o = cnt_word(out_f); end
            4'd2:  begin addr_o = ADDR_W'(8'h09); mask_o = 16'h7FFF; val_o = ctl_word(out_f); end
            4'd3:  begin addr_o = ADDR_W'(8'h07); mask_o = 16'h3C00; val_o = ph_word(out_f);  end
            4'd4:  begin addr_o = ADDR_W'(8'h16); mask_o = 16'h3FFF; val_o = in_word;         end
            4'd5:  begin addr_o = ADDR_W'(8'h14); mask_o = 16'hEFFF; val_o = cnt_word(fb_f);  end
            4'd6:  begin addr_o = ADDR_W'(8'h15); mask_o = 16'h7FFF; val_o = ctl_word(fb_f);  end
            4'd7:  begin addr_o = ADDR_W'(8'h13); mask_o = 16'h3C00; val_o = ph_word(fb_f);   end
            4'd8:  begin addr_o = ADDR_W'(8'h18); mask_o = 16'h03FF; val_o = {6'd0, lock_i[9:0]}; end
            4'd9:  begin addr_o = ADDR_W'(8'h19); mask_o = 16'h7FFF; val_o = {1'b0, lock_i[20:16], 10'h001}; end
            4'd10: begin addr_o = ADDR_W'(8'h1A); mask_o = 16'h7FFF; val_o = {1'b0, lock_i[28:24], 10'h3E9}; end
            4'd11: begin addr_o = ADDR_W'(8'h4E); mask_o = 16'h9900; val_o = filter_i[31:16]; end
            4'd12: begin addr_o = ADDR_W'(8'h4F); mask_o = 16'h9900; val_o = filter_i[15:0];  end
            default: begin addr_o = '0; mask_o = '0; val_o = '0; end
        endcase
    end

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
    import clkcfg_pkg::*;
#(
    parameter int MULT_W   = 10,
    parameter int DIVIN_W  = 7,
    parameter int DIVOUT_W = 11,
    parameter int ADDR_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MULT_W-1:0]   mult_i,
    input  logic [DIVIN_W-1:0]  divin_i,
    input  logic [DIVOUT_W-1:0] divout_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                cfg_en_o,
    output logic                cfg_we_o,
    output logic [ADDR_W-1:0]   cfg_addr_o,
    output logic [WORD_W-1:0]   cfg_wdata_o,
    input  logic [WORD_W-1:0]   cfg_rdata_i,
    input  logic                cfg_rdy_i
);

    localparam int NUM_CH = 3;

    seq_state_e          state_q, state_d;
    logic [STEP_W-1:0]   step_q;
    logic [WORD_W-1:0]   rdata_q;
    logic                err_q;
    logic [MULT_W-1:0]   mult_q;
    logic [DIVIN_W-1:0]  divin_q;
    logic [DIVOUT_W-1:0] divout_q;

    logic req_ok;
    logic last_step;
    logic accept;

    assign req_ok    = (mult_i[MULT_W-1:3] != '0) && (divin_i != '0) &&
                       (divout_i[DIVOUT_W-1:3] != '0);
    assign last_step = (step_q == STEP_W'(NUM_STEPS - 1));
    assign accept    = (state_q == ST_IDLE) && start_i;

    // Divider encoders: 0 = output divider, 1 = input divider, 2 = multiplier
    logic [CNT_W-1:0] ch_int  [NUM_CH];
    logic [2:0]       ch_frac [NUM_CH];
    div_fields_t      ch_fld  [NUM_CH];

    assign ch_int[0]  = CNT_W'(divout_q[DIVOUT_W-1:3]);
    assign ch_frac[0] = divout_q[2:0];
    assign ch_int[1]  = CNT_W'(divin_q);
    assign ch_frac[1] = 3'd0;
    assign ch_int[2]  = CNT_W'(mult_q[MULT_W-1:3]);
    assign ch_frac[2] = mult_q[2:0];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_enc
            clkcfg_div_enc u_enc (
                .int_i  (ch_int[c]),
                .frac_i (ch_frac[c]),
                .fld_o  (ch_fld[c])
            );
        end
    endgenerate

    logic [MULT_W-1:0] lut_idx;
    logic [31:0]       lock_w;
    logic [31:0]       filter_w;
    logic [WORD_W-1:0] power_w;

    assign lut_idx = mult_q - MULT_W'(1);
    assign power_w = ((mult_q[2:0] != 3'd0) || (divout_q[2:0] != 3'd0)) ? 16'h9800 : 16'h0000;

    clkcfg_lut #(.IDX_W(MULT_W)) u_lut (
        .idx_i    (lut_idx),
        .lock_o   (lock_w),
        .filter_o (filter_w)
    );

    logic [ADDR_W-1:0] step_addr;
    logic [WORD_W-1:0] step_mask;
    logic [WORD_W-1:0] step_val;

    clkcfg_step_map #(.ADDR_W(ADDR_W)) u_map (
        .step_i   (step_q),
        .out_f    (ch_fld[0]),
        .in_f     (ch_fld[1]),
        .fb_f     (ch_fld[2]),
        .lock_i   (lock_w),
        .filter_i (filter_w),
        .power_i  (power_w),
        .addr_o   (step_addr),
        .mask_o   (step_mask),
        .val_o    (step_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i && req_ok) state_d = ST_RD_REQ;
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (cfg_rdy_i) state_d = ST_WR_REQ;
            ST_WR_REQ:  state_d = ST_WR_WAIT;
            ST_WR_WAIT: if (cfg_rdy_i) state_d = last_step ? ST_FINISH : ST_RD_REQ;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
            mult_q   <= '0;
            divin_q  <= '0;
            divout_q <= '0;
        end else begin
            err_q <= accept && !req_ok;
            if (accept && req_ok) begin
                mult_q   <= mult_i;
                divin_q  <= divin_i;
                divout_q <= divout_i;
                step_q   <= '0;
            end
            if (state_q == ST_RD_WAIT && cfg_rdy_i) rdata_q <= cfg_rdata_i;
            if (state_q == ST_WR_WAIT && cfg_rdy_i && !last_step) step_q <= step_q + STEP_W'(1);
        end
    end

    // Outputs
    always_comb begin
        cfg_en_o    = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
        cfg_we_o    = (state_q == ST_WR_REQ);
        cfg_addr_o  = step_addr;
        cfg_wdata_o = (rdata_q & ~step_mask) | (step_val & step_mask);
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FINISH);
        err_o       = err_q;
    end

endmodule

// File: rtl/clkcfg_seq_chk.sv
module clkcfg_seq_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              cfg_en_o,
    input logic              cfg_we_o,
    input logic [ADDR_W-1:0] cfg_addr_o,
    input logic              cfg_rdy_i
);

    logic              pend_q;
    logic [ADDR_W-1:0] last_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            last_rd_q <= '0;
        end else begin
            if (cfg_en_o)       pend_q <= 1'b1;
            else if (cfg_rdy_i) pend_q <= 1'b0;
            if (cfg_en_o && !cfg_we_o) last_rd_q <= cfg_addr_o;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_en_o |=> !cfg_en_o); // R4
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) cfg_en_o |-> !pend_q); // R4
    AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (cfg_en_o && cfg_we_o) |-> (cfg_addr_o == last_rd_q)); // R2
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o); // R1
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err_o |-> (!busy_o && !cfg_en_o)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R12
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done_o, err_o, cfg_en_o})); // R12
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cfg_en_o |-> busy_o); // R12
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> !err_o); // R13

endmodule

bind clkcfg_seq clkcfg_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .cfg_en_o   (cfg_en_o),
    .cfg_we_o   (cfg_we_o),
    .cfg_addr_o (cfg_addr_o),
    .cfg_rdy_i  (cfg_rdy_i)
);

// File: tb/sim_clkcfg_seq.sv
`timescale 1ns/1ps
module sim_clkcfg_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  mult = '0;
    logic [6:0]  divin = '0;
    logic [10:0] divout = '0;
    logic        busy_o, done_o, err_o, cfg_en_o, cfg_we_o;
    logic [6:0]  cfg_addr_o;
    logic [15:0] cfg_wdata_o;
    logic [15:0] cfg_rdata = '0;
    logic        cfg_rdy = 1'b0;

    always #10 clk = ~clk;

    clkcfg_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mult_i(mult), .divin_i(divin),
        .divout_i(divout), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .cfg_en_o(cfg_en_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
        .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata), .cfg_rdy_i(cfg_rdy)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Port model and monitors
    logic [15:0] mem [128];
    logic        pend = 1'b0;
    logic        p_we = 1'b0;
    logic [6:0]  p_addr = '0;
    logic [15:0] p_wd = '0;
    int          lat = 0;
    int          nops = 0;
    int          overlap = 0;
    int          cyc = 0;
    int          last_rdy_cyc = 0;
    int          done_cyc = 0;
    int          done_cnt = 0;
    int          err_cnt = 0;
    logic        op_we [64];
    logic [6:0]  op_addr [64];
    logic [15:0] op_data [64];

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cfg_rdy) last_rdy_cyc = cyc;
        if (done_o) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
        if (err_o) err_cnt = err_cnt + 1;
        cfg_rdy <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (cfg_en_o) begin
            if (pend) overlap = overlap + 1;
            pend   <= 1'b1;
            p_we   <= cfg_we_o;
            p_addr <= cfg_addr_o;
            p_wd   <= cfg_wdata_o;
            lat    <= nops % 3;
            if (nops < 64) begin
                op_we[nops]   = cfg_we_o;
                op_addr[nops] = cfg_addr_o;
                op_data[nops] = cfg_wdata_o;
            end
            nops = nops + 1;
        end else if (pend) begin
            if (lat == 0) begin
                cfg_rdy   <= 1'b1;
                pend      <= 1'b0;
                cfg_rdata <= mem[p_addr];
                if (p_we) mem[p_addr] <= p_wd;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    function automatic logic [15:0] init_word(int a);
        return 16'((32'hC3A5 ^ (a * 263)) & 32'hFFFF);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int a = 0; a < 128; a++) mem[a] = init_word(a);
        nops = 0; overlap = 0; done_cnt = 0; err_cnt = 0;
    endtask

    task automatic pulse_start(input int m, input int d, input int o);
        @(negedge clk);
        start = 1'b1; mult = 10'(m); divin = 7'(d); divout = 11'(o);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Divider encoding written from R5, R6, R7
    function automatic void enc(input int dv, input int f, output int hi, output int lo,
                                output int od, output int nc, output int fe, output int fr,
                                output int wr, output int wf, output int ph);
        hi = 0; lo = 0; od = 0; nc = 0; fe = 0; fr = 0; wr = 0; wf = 0; ph = 0;
        if (dv == 1) nc = 1;
        else if (f == 0) begin hi = dv / 2; od = dv % 2; lo = dv - hi; end
        else begin
            fe = 1; fr = f; hi = dv / 2; od = dv % 2; lo = hi;
            if (od == 0) begin hi = hi - 1; wr = 1; end
            if (od == 0 || f == 1) lo = lo - 1;
            if (((od == 0) != (f == 1)) || (dv == 2 && f == 1)) wf = 1;
            ph = od * 4 + f / 2;
        end
    endfunction

    // Full sequence run with expected values per R2, R3, R8, R9, R10, R11, R12
    task automatic run_seq(input int m, input int d, input int o, input int lock, input int filt,
                           input string enc_tag, input bit poke);
        int ea [13];
        int em [13];
        int ev [13];
        int hi, lo, od, nc, fe, fr, wr, wf, ph;
        bit seen;
        clear_logs();
        ea = '{'h28, 'h08, 'h09, 'h07, 'h16, 'h14, 'h15, 'h13, 'h18, 'h19, 'h1A, 'h4E, 'h4F};
        em = '{'h9800, 'hEFFF, 'h7FFF, 'h3C00, 'h3FFF, 'hEFFF, 'h7FFF, 'h3C00,
               'h03FF, 'h7FFF, 'h7FFF, 'h9900, 'h9900};
        ev[0] = ((m % 8) != 0 || (o % 8) != 0) ? 'h9800 : 0;
        enc(o / 8, o % 8, hi, lo, od, nc, fe, fr, wr, wf, ph);
        ev[1] = (hi << 6) | lo;
        ev[2] = (fr << 12) | (fe << 11) | (wr << 10) | (od << 7) | (nc << 6);
        ev[3] = (ph << 11) | (wf << 10);
        enc(d, 0, hi, lo, od, nc, fe, fr, wr, wf, ph);
        ev[4] = (od << 13) | (nc << 12) | (hi << 6) | lo;
        enc(m / 8, m % 8, hi, lo, od, nc, fe, fr, wr, wf, ph);
        ev[5] = (hi << 6) | lo;
        ev[6] = (fr << 12) | (fe << 11) | (wr << 10) | (od << 7) | (nc << 6);
        ev[7] = (ph << 11) | (wf << 10);
        ev[8] = lock & 'h3FF;
        ev[9] = (((lock >> 16) & 'h1F) << 10) | 'h001;
        ev[10] = (((lock >> 24) & 'h1F) << 10) | 'h3E9;
        ev[11] = (filt >> 16) & 'hFFFF;
        ev[12] = filt & 'hFFFF;

        pulse_start(m, d, o);
        chk(busy_o == 1'b1, "R12", "busy after start", int'(busy_o), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            // R13: invalid start in mid-sequence
            start = 1'b1; mult = 10'd0; divin = 7'd0; divout = 11'd0;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        if (poke) begin
            // R13: valid start during the done cycle
            start = 1'b1; mult = 10'd100; divin = 7'd2; divout = 11'd40;
        end
        @(negedge clk);
        start = 1'b0;
        chk(seen, "R12", "done seen", int'(seen), 1);
        chk(busy_o == 1'b0, "R12", "busy after done", int'(busy_o), 0);
        chk(done_cnt == 1, "R12", "done pulse count", done_cnt, 1);
        chk(done_cyc == last_rdy_cyc + 1, "R12", "done timing", done_cyc - last_rdy_cyc, 1);
        chk(overlap == 0, "R4", "overlapping requests", overlap, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(busy_o == 1'b0, "R13", "busy after ignored start", int'(busy_o), 0);
            chk(err_cnt == 0, "R13", "error cycles", err_cnt, 0);
        end
        chk(nops == 26, "R2", "operation count", nops, 26);
        for (int i = 0; i < 13; i++) begin
            string tag;
            int expw;
            if (i == 0) tag = "R9";
            else if (i <= 7) tag = (i == 4) ? "R8" : enc_tag;
            else if (i <= 10) tag = "R10";
            else tag = "R11";
            chk(op_we[2*i] == 1'b0 && int'(op_addr[2*i]) == ea[i], "R2", "read address",
                int'(op_addr[2*i]), ea[i]);
            chk(op_we[2*i+1] == 1'b1 && int'(op_addr[2*i+1]) == ea[i], "R2", "write address",
                int'(op_addr[2*i+1]), ea[i]);
            expw = (int'(init_word(ea[i])) & ~em[i] & 'hFFFF) | (ev[i] & em[i]);
            chk(int'(op_data[2*i+1]) == expw, tag, $sformatf("R3 merged data step %0d", i),
                int'(op_data[2*i+1]), expw);
        end
    endtask

    task automatic test_reset();
        chk(busy_o == 0 && done_o == 0 && err_o == 0 && cfg_en_o == 0, "R12", "reset outputs",
            {busy_o, done_o, err_o, cfg_en_o}, 0);
    endtask

    task automatic test_reject(input int m, input int d, input int o);
        clear_logs();
        pulse_start(m, d, o);
        chk(err_o == 1'b1, "R1", "error pulse", int'(err_o), 1);
        chk(busy_o == 1'b0, "R1", "busy on reject", int'(busy_o), 0);
        @(negedge clk);
        chk(err_o == 1'b0, "R1", "error cleared", int'(err_o), 0);
        repeat (4) @(negedge clk);
        chk(nops == 0, "R1", "port traffic on reject", nops, 0);
    endtask

    // Scenario wrappers
    task automatic test_integer();      run_seq(320, 3, 80, 'h1F1F00FA, 'h08008090, "R6", 0); endtask // R6, index 319
    task automatic test_fraction();     run_seq(19, 2, 21, 'h1F1F020D, 'h01001090, "R7", 0); endtask  // R7, index 18
    task automatic test_bypass();       run_seq(8, 1, 25, 'h161603E8, 'h01009090, "R5", 0); endtask   // R5, index 7
    task automatic test_two_eighth();   run_seq(17, 5, 64, 'h1F1F023F, 'h01001090, "R7", 0); endtask  // R7 n=2 f=1
    task automatic test_lock_edge();    run_seq(37, 1, 16, 'h1F1F00FA, 'h01008090, "R6", 0); endtask  // R10 index 36
    task automatic test_filter_edge();  run_seq(47, 4, 33, 'h1F1F00FA, 'h08001090, "R7", 0); endtask  // R11 index 46
    task automatic test_busy_start();   run_seq(19, 2, 21, 'h1F1F020D, 'h01001090, "R7", 1); endtask  // R13

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_reject(0, 3, 80);
        test_reject(320, 0, 80);
        test_reject(320, 3, 5);
        test_integer();
        test_fraction();
        test_bypass();
        test_two_eighth();
        test_lock_edge();
        test_filter_edge();
        test_busy_start();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule